// File: doc/BRIEF.md
# Instruction Timing Sequencer for a Small-Area Integer Core

This block is the control state machine of a compact RISC-V integer core. Every cycle it looks at the class of the instruction in execution, as reported by an external pre-decoder, and at the branch-compare result. From these it decides how many cycles the instruction occupies and in which of those cycles the core fetches, touches data memory, writes the register file and moves the program counter. A thin datapath next to it holds the program counter and the instruction register.

A build parameter picks one of two bus arrangements. With split buses, instructions come from a dedicated program port while loads and stores use the data bus, so the two can overlap. With one shared bus, instruction fetch also travels over the data bus. The program address output still shows the PC, but the dedicated instruction input is not used. Sharing the bus only stretches loads and stores, because those are the only classes where a data access and a fetch would collide.

Register-file reads are registered block-RAM reads, so compare operands are not ready until one cycle after an instruction starts. The sequencer therefore evaluates a conditional branch in the second cycle of that instruction.

Top module: `instr_timing_seq`

## Requirements
- R1: While reset is low, the PC holds parameter RESET_VEC and the instruction register holds zero. The first cycle after reset is a fetch: irLoad=1, rfWe=0, pcEn=0, busWe=0, and busRe=1 only in shared-bus mode.
- R2: Class code 0 (register/immediate ALU) takes one cycle. rfWe=1 and the PC advances by 4 (pcSel=0) in that cycle.
- R3: Class code 1 (load) takes 2 cycles with split buses and 3 cycles with a shared bus. rfWe is high in exactly one cycle, the second, and the PC advances by 4.
- R4: Class code 2 (store) takes 1 cycle with split buses and 3 cycles with a shared bus. busWe is high in exactly one cycle, the first. With a shared bus, busWe is never high in a cycle with busRe or irLoad.
- R5: Class code 3 (unconditional jump) takes 2 cycles in both modes. Its first cycle asserts rfWe, pcEn and pcSel=1, and the PC becomes jumpTarget. Its second cycle refetches with rfWe=0.
- R6: Class code 4 (conditional branch) samples branchTaken in its second cycle. If not taken, it takes 2 cycles and the PC advances by 4. If taken, it takes 3 cycles: pcSel=2, the PC becomes branchTarget, and the last cycle refetches with rfWe=0. The PC does not move in the first cycle.
- R7: With a shared bus, every cycle with irLoad=1 also has busRe=1 and busAddrSel=0 (address from the PC), and the instruction register loads from busRdata while imemData is ignored. With split buses, the instruction register loads from imemData and busRe is never high in a fetch cycle.
- R8: Every data access (busWe=1, or busRe=1 outside a fetch) has busAddrSel=1 (address from the ALU result).
- R9: Class codes 5, 6 and 7 act as a one-cycle no-op: rfWe=0, busWe=0, and the PC advances by 4.
- R10: The program address output always equals the PC register. The PC changes only at a clock edge where pcEn was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instrClass | input | 3 | Pre-decoded class of the instruction in execution |
| branchTaken | input | 1 | Branch compare result, sampled in a branch's second cycle |
| imemData | input | XLEN | Instruction word from the dedicated program port |
| busRdata | input | XLEN | Read data from the data bus |
| jumpTarget | input | XLEN | Computed unconditional jump target |
| branchTarget | input | XLEN | Computed conditional branch target |
| progAddr | output | XLEN | Program address (the PC register) |
| instrWord | output | XLEN | Instruction register |
| busAddrSel | output | 1 | Data-bus address select: 0 PC, 1 ALU result |
| busRe | output | 1 | Data-bus read strobe |
| busWe | output | 1 | Data-bus write strobe |
| irLoad | output | 1 | Instruction-register load |
| rfWe | output | 1 | Register-file write enable |
| pcSel | output | 2 | Next-PC select: 0 PC+4, 1 jump target, 2 branch target |
| pcEn | output | 1 | PC update enable |

## Verification
All strobes are combinational from the state and the class input, so each one is due in the same cycle it belongs to. The bench samples them at the falling edge of that cycle and counts falling edges from one irLoad pulse to the next to get an instruction's length. The PC and instruction register take effect one edge after the strobe that moves them. The bench therefore checks them just after the rising edge that ends an instruction, when every update of that instruction has settled. It checks the unchanged PC in a branch's second cycle, after a first cycle with pcEn low.

// File: rtl/seq_pkg.sv
`timescale 1ns/1ps
package seq_pkg;

  localparam logic [2:0] CLS_ALU    = 3'd0;
  localparam logic [2:0] CLS_LOAD   = 3'd1;
  localparam logic [2:0] CLS_STORE  = 3'd2;
  localparam logic [2:0] CLS_JUMP   = 3'd3;
  localparam logic [2:0] CLS_BRANCH = 3'd4;

  localparam logic ADDR_PC  = 1'b0;
  localparam logic ADDR_ALU = 1'b1;

  typedef enum logic [1:0] {
    PCS_SEQ    = 2'd0,
    PCS_JUMP   = 2'd1,
    PCS_BRANCH = 2'd2
  } pcSel_e;

  typedef enum logic [1:0] {
    ST_FETCH = 2'd0,
    ST_EXEC  = 2'd1,
    ST_MEM   = 2'd2,
    ST_BRCMP = 2'd3
  } seqState_e;

  typedef struct packed {
    logic   irLoad;
    logic   pcEn;
    pcSel_e pcSel;
    logic   rfWe;
    logic   busRe;
    logic   busWe;
    logic   busAddrSel;
  } strobes_t;

endpackage

// File: rtl/seq_control.sv
`timescale 1ns/1ps
module seq_control
  import seq_pkg::*;
#(
  parameter bit SINGLE_BUS = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] instrClass,
  input  logic       branchTaken,
  output strobes_t   strobes
);

  localparam logic SHARED = SINGLE_BUS;

  seqState_e stCur, stNext;
  logic      memIsLoad, memIsLoadNext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stCur     <= ST_FETCH;
      memIsLoad <= 1'b0;
    end else begin
      stCur     <= stNext;
      memIsLoad <= memIsLoadNext;
    end
  end

  always_comb begin
    strobes       = '0;
    strobes.pcSel = PCS_SEQ;
    stNext        = stCur;
    memIsLoadNext = memIsLoad;
    unique case (stCur)
      ST_FETCH: begin
        strobes.irLoad     = 1'b1;
        strobes.busRe      = SHARED;
        strobes.busAddrSel = ADDR_PC;
        stNext             = ST_EXEC;
      end
      ST_EXEC: begin
        case (instrClass)
          CLS_ALU: begin
            strobes.rfWe       = 1'b1;
            strobes.pcEn       = 1'b1;
            strobes.irLoad     = 1'b1;
            strobes.busRe      = SHARED;
            strobes.busAddrSel = ADDR_PC;
          end
          CLS_LOAD: begin
            strobes.busRe      = 1'b1;
            strobes.busAddrSel = ADDR_ALU;
            memIsLoadNext      = 1'b1;
            stNext             = ST_MEM;
          end
          CLS_STORE: begin
            strobes.busWe      = 1'b1;
            strobes.busAddrSel = ADDR_ALU;
            if (SHARED) begin
              memIsLoadNext = 1'b0;
              stNext        = ST_MEM;
            end else begin
              strobes.pcEn   = 1'b1;
              strobes.irLoad = 1'b1;
            end
          end
          CLS_JUMP: begin
            strobes.rfWe  = 1'b1;
            strobes.pcEn  = 1'b1;
            strobes.pcSel = PCS_JUMP;
            stNext        = ST_FETCH;
          end
          CLS_BRANCH: begin
            stNext = ST_BRCMP;
          end
          default: begin
            strobes.pcEn       = 1'b1;
            strobes.irLoad     = 1'b1;
            strobes.busRe      = SHARED;
            strobes.busAddrSel = ADDR_PC;
          end
        endcase
      end
      ST_MEM: begin
        strobes.rfWe = memIsLoad;
        strobes.pcEn = 1'b1;
        if (SHARED) begin
          stNext = ST_FETCH;
        end else begin
          strobes.irLoad = 1'b1;
          stNext         = ST_EXEC;
        end
      end
      ST_BRCMP: begin
        strobes.pcEn = 1'b1;
        if (branchTaken) begin
          strobes.pcSel = PCS_BRANCH;
          stNext        = ST_FETCH;
        end else begin
          strobes.irLoad     = 1'b1;
          strobes.busRe      = SHARED;
          strobes.busAddrSel = ADDR_PC;
          stNext             = ST_EXEC;
        end
      end
      default: stNext = ST_FETCH;
    endcase
  end

endmodule

// File: rtl/seq_datapath.sv
`timescale 1ns/1ps
module seq_datapath
  import seq_pkg::*;
#(
  parameter int              XLEN       = 32,
  parameter logic [XLEN-1:0] RESET_VEC  = '0,
  parameter bit              SINGLE_BUS = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  strobes_t        strobes,
  input  logic [XLEN-1:0] imemData,
  input  logic [XLEN-1:0] busRdata,
  input  logic [XLEN-1:0] jumpTarget,
  input  logic [XLEN-1:0] branchTarget,
  output logic [XLEN-1:0] pc,
  output logic [XLEN-1:0] ir
);

  localparam logic [XLEN-1:0] INSTR_BYTES = XLEN'(4);

  logic [XLEN-1:0] pcNext, irSrc;
  logic            unusedStrobes;

  assign unusedStrobes = strobes.rfWe ^ strobes.busRe ^ strobes.busWe ^ strobes.busAddrSel;

  generate
    if (SINGLE_BUS) begin : gSharedFetch
      logic unusedImem;
      assign unusedImem = ^imemData;
      assign irSrc      = busRdata;
    end else begin : gSplitFetch
      logic unusedBus;
      assign unusedBus = ^busRdata;
      assign irSrc     = imemData;
    end
  endgenerate

  always_comb begin
    unique case (strobes.pcSel)
      PCS_JUMP:   pcNext = jumpTarget;
      PCS_BRANCH: pcNext = branchTarget;
      default:    pcNext = pc + INSTR_BYTES;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= RESET_VEC;
      ir <= '0;
    end else begin
      if (strobes.pcEn)   pc <= pcNext;
      if (strobes.irLoad) ir <= irSrc;
    end
  end

endmodule

// File: rtl/instr_timing_seq.sv
`timescale 1ns/1ps
module instr_timing_seq
  import seq_pkg::*;
#(
  parameter int              XLEN       = 32,
  parameter logic [XLEN-1:0] RESET_VEC  = XLEN'(32'h0000_0100),
  parameter bit              SINGLE_BUS = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      instrClass,
  input  logic            branchTaken,
  input  logic [XLEN-1:0] imemData,
  input  logic [XLEN-1:0] busRdata,
  input  logic [XLEN-1:0] jumpTarget,
  input  logic [XLEN-1:0] branchTarget,
  output logic [XLEN-1:0] progAddr,
  output logic [XLEN-1:0] instrWord,
  output logic            busAddrSel,
  output logic            busRe,
  output logic            busWe,
  output logic            irLoad,
  output logic            rfWe,
  output logic [1:0]      pcSel,
  output logic            pcEn
);

  strobes_t strobes;

  seq_control #(.SINGLE_BUS(SINGLE_BUS)) uCtrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .instrClass (instrClass),
    .branchTaken(branchTaken),
    .strobes    (strobes)
  );

  seq_datapath #(.XLEN(XLEN), .RESET_VEC(RESET_VEC), .SINGLE_BUS(SINGLE_BUS)) uPath (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobes     (strobes),
    .imemData    (imemData),
    .busRdata    (busRdata),
    .jumpTarget  (jumpTarget),
    .branchTarget(branchTarget),
    .pc          (progAddr),
    .ir          (instrWord)
  );

  assign busAddrSel = strobes.busAddrSel;
  assign busRe      = strobes.busRe;
  assign busWe      = strobes.busWe;
  assign irLoad     = strobes.irLoad;
  assign rfWe       = strobes.rfWe;
  assign pcSel      = strobes.pcSel;
  assign pcEn       = strobes.pcEn;

endmodule

// File: rtl/instr_timing_seq_chk.sv
`timescale 1ns/1ps
module instr_timing_seq_chk #(
  parameter int XLEN       = 32,
  parameter bit SINGLE_BUS = 1'b0
) (
  input logic            clk,
  input logic            rst_n,
  input logic            irLoad,
  input logic            rfWe,
  input logic            busRe,
  input logic            busWe,
  input logic            busAddrSel,
  input logic            pcEn,
  input logic [1:0]      pcSel,
  input logic [XLEN-1:0] progAddr
);

  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !pcEn |=> $stable(progAddr)); // R10

  AST_REDIRECT_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
    (pcEn && pcSel != 2'd0) |=> (irLoad && !rfWe && !pcEn)); // R5

  AST_WRITE_ADDR_ALU: assert property (@(posedge clk) disable iff (!rst_n)
    busWe |-> busAddrSel); // R8

  AST_WB_NOT_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    rfWe |-> !busWe); // R4

  generate
    if (SINGLE_BUS) begin : gShared
      AST_SHARED_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        irLoad |-> (busRe && !busAddrSel)); // R7
      AST_STORE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        busWe |-> (!busRe && !irLoad)); // R4
    end else begin : gSplit
      AST_SPLIT_READ_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        busRe |-> (busAddrSel && !irLoad)); // R7
    end
  endgenerate

endmodule

bind instr_timing_seq instr_timing_seq_chk #(.XLEN(XLEN), .SINGLE_BUS(SINGLE_BUS)) uChk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irLoad    (irLoad),
  .rfWe      (rfWe),
  .busRe     (busRe),
  .busWe     (busWe),
  .busAddrSel(busAddrSel),
  .pcEn      (pcEn),
  .pcSel     (pcSel),
  .progAddr  (progAddr)
);

// File: tb/tb_instr_timing_seq.sv
`timescale 1ns/1ps
module tb_instr_timing_seq;

  localparam logic [31:0] RST_VEC = 32'h0000_0100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int failures = 0;
  int seqNo = 0;
  bit mode = 1'b0;
  logic [31:0] tbPc;

  logic [2:0]  clsD, clsS;
  logic        tkD, tkS;
  logic [31:0] imD, imS, rdD, rdS, jtD, jtS, btD, btS;
  logic [31:0] progD, progS, irD, irS;
  logic        selD, selS, reD, reS, weD, weS, ilD, ilS, rfD, rfS, peD, peS;
  logic [1:0]  psD, psS;

  instr_timing_seq #(.XLEN(32), .RESET_VEC(RST_VEC), .SINGLE_BUS(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .instrClass(clsD), .branchTaken(tkD),
    .imemData(imD), .busRdata(rdD), .jumpTarget(jtD), .branchTarget(btD),
    .progAddr(progD), .instrWord(irD), .busAddrSel(selD), .busRe(reD),
    .busWe(weD), .irLoad(ilD), .rfWe(rfD), .pcSel(psD), .pcEn(peD));

  instr_timing_seq #(.XLEN(32), .RESET_VEC(RST_VEC), .SINGLE_BUS(1'b1)) dutSingle (
    .clk(clk), .rst_n(rst_n), .instrClass(clsS), .branchTaken(tkS),
    .imemData(imS), .busRdata(rdS), .jumpTarget(jtS), .branchTarget(btS),
    .progAddr(progS), .instrWord(irS), .busAddrSel(selS), .busRe(reS),
    .busWe(weS), .irLoad(ilS), .rfWe(rfS), .pcSel(psS), .pcEn(peS));

  logic [31:0] oProg, oIr;
  logic        oSel, oRe, oWe, oIl, oRf, oPe;
  assign oProg = mode ? progS : progD;
  assign oIr   = mode ? irS   : irD;
  assign oSel  = mode ? selS  : selD;
  assign oRe   = mode ? reS   : reD;
  assign oWe   = mode ? weS   : weD;
  assign oIl   = mode ? ilS   : ilD;
  assign oRf   = mode ? rfS   : rfD;
  assign oPe   = mode ? peS   : peD;

  // table entry: [7:5] class, [4] taken, [3:2] split-bus cycles, [1:0] shared-bus cycles
  localparam logic [7:0] VEC [16] = '{
    {3'd0, 1'b0, 2'd1, 2'd1}, {3'd1, 1'b0, 2'd2, 2'd3},
    {3'd1, 1'b1, 2'd2, 2'd3}, {3'd2, 1'b0, 2'd1, 2'd3},
    {3'd2, 1'b0, 2'd1, 2'd3}, {3'd0, 1'b1, 2'd1, 2'd1},
    {3'd3, 1'b0, 2'd2, 2'd2}, {3'd4, 1'b1, 2'd3, 2'd3},
    {3'd4, 1'b0, 2'd2, 2'd2}, {3'd2, 1'b0, 2'd1, 2'd3},
    {3'd1, 1'b0, 2'd2, 2'd3}, {3'd4, 1'b1, 2'd3, 2'd3},
    {3'd3, 1'b1, 2'd2, 2'd2}, {3'd5, 1'b0, 2'd1, 2'd1},
    {3'd7, 1'b1, 2'd1, 2'd1}, {3'd0, 1'b0, 2'd1, 2'd1}
  };

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s (mode=%0d): actual=%0h expected=%0h", tag, what, mode, act, exp);
    end
  endtask

  function automatic string tagOf(input logic [2:0] c);
    case (c)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      default: return "R9";
    endcase
  endfunction

  function automatic int expCycles(input bit single, input logic [2:0] c, input bit tk);
    case (c)
      3'd1: return single ? 3 : 2;
      3'd2: return single ? 3 : 1;
      3'd3: return 2;
      3'd4: return tk ? 3 : 2;
      default: return 1;
    endcase
  endfunction

  task automatic drive(input logic [2:0] c, input bit tk, input logic [31:0] im,
                       input logic [31:0] rd, input logic [31:0] jt, input logic [31:0] bt);
    if (mode) begin
      clsS = c; tkS = tk; imS = im; rdS = rd; jtS = jt; btS = bt;
    end else begin
      clsD = c; tkD = tk; imD = im; rdD = rd; jtD = jt; btD = bt;
    end
  endtask

  task automatic doReset();
    rst_n = 1'b0;
    clsD = 3'd0; tkD = 1'b0; imD = '0; rdD = '0; jtD = '0; btD = '0;
    clsS = 3'd0; tkS = 1'b0; imS = '0; rdS = '0; jtS = '0; btS = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(oProg == RST_VEC, "R1", "PC in reset", oProg, RST_VEC);
    chk(oIr == 32'd0, "R1", "IR in reset", oIr, 32'd0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk(oIl == 1'b1, "R1", "first cycle irLoad", {31'd0, oIl}, 32'd1);
    chk(!oRf && !oPe && !oWe, "R1", "first cycle rfWe/pcEn/busWe", {29'd0, oRf, oPe, oWe}, 32'd0);
    chk(oRe == mode, "R1", "first cycle busRe", {31'd0, oRe}, {31'd0, mode});
    @(posedge clk); #1;
    tbPc = RST_VEC;
  endtask

  // Entered one delta after the edge that starts the instruction's first cycle.
  task automatic runInstr(input logic [2:0] c, input bit tk, input int expCyc);
    int n = 0;
    int rfCnt = 0;
    int weCnt = 0;
    bit rfLast = 1'b0;
    bit done = 1'b0;
    logic [31:0] pcFirst = '0;
    logic [31:0] imV = 32'hA000_0000 | seqNo;
    logic [31:0] rdV = 32'h5000_0000 | seqNo;
    logic [31:0] jt  = 32'h0000_2000 + seqNo * 16;
    logic [31:0] bt  = 32'h0000_4000 + seqNo * 8;
    logic [31:0] expPc;
    string tag = tagOf(c);
    seqNo++;
    drive(c, tk, imV, rdV, jt, bt);
    if (c == 3'd3) expPc = jt;
    else if (c == 3'd4 && tk) expPc = bt;
    else expPc = tbPc + 32'd4;
    while (!done) begin
      @(negedge clk);
      n++;
      if (n == 1) pcFirst = oProg;
      if (c == 3'd4 && n == 2)
        chk(oProg == pcFirst, "R10", "PC held in branch first cycle", oProg, pcFirst);
      if (oRf) rfCnt++;
      if (oWe) weCnt++;
      if (c == 3'd1 && oRf)
        chk(n == 2, "R3", "load writeback cycle", n, 2);
      if (c == 3'd2 && oWe)
        chk(n == 1, "R4", "store write cycle", n, 1);
      if (oWe || (oRe && !oIl))
        chk(oSel == 1'b1, "R8", "data access address from ALU", {31'd0, oSel}, 32'd1);
      if (mode && oWe)
        chk(!oRe && !oIl, "R4", "write alone on shared bus", {30'd0, oRe, oIl}, 32'd0);
      if (oIl) begin
        done = 1'b1;
        rfLast = oRf;
        if (mode) chk(oRe && !oSel, "R7", "shared fetch on bus from PC", {30'd0, oRe, oSel}, 32'd2);
        else      chk(!oRe, "R7", "split fetch leaves data bus idle", {31'd0, oRe}, 32'd0);
      end else if (n >= 8) begin
        done = 1'b1;
      end
      @(posedge clk); #1;
    end
    chk(n == expCyc, tag, "cycle count", n, expCyc);
    chk(rfCnt == ((c == 3'd0 || c == 3'd1 || c == 3'd3) ? 1 : 0), tag, "rfWe count",
        rfCnt, (c == 3'd0 || c == 3'd1 || c == 3'd3) ? 1 : 0);
    chk(weCnt == ((c == 3'd2) ? 1 : 0), tag, "busWe count", weCnt, (c == 3'd2) ? 1 : 0);
    if (c == 3'd3 || (c == 3'd4 && tk))
      chk(!rfLast, tag, "refetch slot has no writeback", {31'd0, rfLast}, 32'd0);
    chk(oProg == expPc, tag, "PC after instruction", oProg, expPc);
    chk(oIr == (mode ? rdV : imV), "R7", "IR source", oIr, mode ? rdV : imV);
    tbPc = expPc;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog R1: actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    for (int m = 0; m < 2; m++) begin
      mode = (m == 1);
      doReset();
      for (int i = 0; i < 16; i++) begin
        runInstr(VEC[i][7:5], VEC[i][4], mode ? int'(VEC[i][1:0]) : int'(VEC[i][3:2]));
      end
      lfsr = 16'hACE1;
      for (int i = 0; i < 60; i++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        runInstr(lfsr[2:0], lfsr[3], expCycles(mode, lfsr[2:0], lfsr[3]));
      end
      // directed: reset arriving in the middle of a taken branch (R1)
      drive(3'd4, 1'b1, 32'h1, 32'h2, 32'h3, 32'h4);
      @(negedge clk);
      @(posedge clk); #1;
      doReset();
      // directed: taken branch straight into store and load (R6, R4, R3)
      runInstr(3'd4, 1'b1, 3);
      runInstr(3'd2, 1'b0, mode ? 3 : 1);
      runInstr(3'd1, 1'b0, mode ? 3 : 2);
      runInstr(3'd3, 1'b0, 2);
      runInstr(3'd6, 1'b0, 1);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule